// File: doc/BRIEF.md
# Asynchronous static memory controller

This block connects a single-request on-chip bus to external asynchronous devices such as SRAM, NOR flash and memory-mapped peripherals. It drives four active-low chip selects, a 24-bit byte address, active-low byte enables and separate read and write strobes. The data bus is split into an input, an output and an output enable, which pad logic combines into one bidirectional bus. Every access runs three phases. In the setup phase the chip select and the address are valid. In the strobe phase a strobe is low. In the hold phase the strobe is released and the chip select stays low.

Each chip select has its own configuration word, written through a simple register port. The word holds the setup, strobe and hold counts, the external data width, whether the strobe waits for the external ready, and whether a ready timeout is armed. When a 32-bit request goes to a narrower region, the block runs back-to-back external cycles with rising addresses and assembles the read data little-endian. Chip select 0 is the boot region. Out of reset its timing is the slowest the fields can express, and its width comes from a 3-bit strap. Whenever no read is in flight, the block drives the data bus high itself, so no external pull-ups are needed.

Top module: `asmc_top`

## Requirements
- R1: In reset and in idle, all chip selects and both strobes are high, the byte enables are all high, `mem_d_oe_o` is 1 with `mem_d_o` all ones, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: `req_cs_i` selects which chip select is low during the access. At most one chip select is low at any time.
- R3: The configuration word is {to_en[17], rdy_en[16], width[15:14], hold[13:10], strobe[9:4], setup[3:0]}. For each external cycle, setup lasts setup+1 cycles and strobe lasts strobe+1 cycles (when ready does not extend it). Hold lasts hold+1 cycles, with the chip select low and both strobes high. The two strobes are never low together.
- R4: The width codes are 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for 8-bit. An access takes 4, 2 or 1 external cycles. The address of cycle k is 4*req_word_i + k*(bytes per cycle), and narrow data uses the low byte lanes.
- R5: Write byte enables follow `req_be_i`. In cycle k of a 16-bit region, the enables are bits 2k+1..2k on lanes 1..0. In cycle k of an 8-bit region, enable bit k is on lane 0. Unused lanes are disabled.
- R6: Read data is assembled little-endian: external cycle k fills response byte k (8-bit region) or halfword k (16-bit region).
- R7: With rdy_en set, the strobe is held past its count until `mem_rdy_ni` is low. With rdy_en clear, `mem_rdy_ni` has no effect.
- R8: With rdy_en and to_en set, if ready stays high for TIMEOUT_CYC cycles after the strobe count expires, the strobe ends and hold runs. No further external cycles start, and the response carries `rsp_err_o`=1.
- R9: Out of reset, every region has setup 15, strobe 63 and hold 15, with ready and timeout off. Regions 1 to 3 are 32-bit. Region 0 takes its width from `boot_mode_i`: 000 gives 8-bit, 001 gives 16-bit, 010 gives 32-bit, and any other code gives 8-bit.
- R10: During write setup and strobe, `mem_d_o` carries data. From the write hold phase on, it is driven all ones. During the whole read access, including hold, `mem_d_oe_o` is 0, and it returns to 1 only once the read hold phase is over.
- R11: `rsp_valid_o` is a one-cycle pulse in the cycle after the last hold cycle. `req_ready_o` is 0 while any chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_mode_i | input | 3 | Boot width strap, sampled during reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Chip select whose configuration is written |
| cfg_wdata_i | input | 18 | Configuration word |
| req_valid_i | input | 1 | Request valid |
| req_write_i | input | 1 | 1 write, 0 read |
| req_cs_i | input | 2 | Target region |
| req_word_i | input | 22 | Word offset inside the region |
| req_be_i | input | 4 | Request byte enables |
| req_wdata_i | input | 32 | Write data |
| req_ready_o | output | 1 | Request accepted when high with valid |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_err_o | output | 1 | Ready timeout occurred |
| rsp_rdata_o | output | 32 | Assembled read data |
| mem_cs_no | output | 4 | Chip selects, active low |
| mem_addr_o | output | 24 | External byte address |
| mem_be_no | output | 4 | Byte enables, active low |
| mem_rd_no | output | 1 | Read strobe, active low |
| mem_wr_no | output | 1 | Write strobe, active low |
| mem_rdy_ni | input | 1 | External ready, active low |
| mem_d_i | input | 32 | Data bus input |
| mem_d_o | output | 32 | Data bus output |
| mem_d_oe_o | output | 1 | Data bus output enable |

## Verification
The bench measures phase lengths at the pins for the slow boot defaults and for programmed fast timing. An off-by-one counter would show up as a setup, strobe or hold length that is one cycle wrong. It runs 8-bit and 16-bit regions with partial byte enables and checks each beat address and the assembled word. A wrong lane shift or beat stride would corrupt bytes or skip addresses. For ready, the bench delays ready on one region and holds it stuck on another, so a design that ignores ready, waits forever or keeps running beats after a timeout is caught. A cycle-by-cycle monitor flags any cycle in which the bus is driven during a read or left undriven in a write hold.

// File: rtl/asmc_pkg.sv
package asmc_pkg;
  localparam int SETUP_W  = 4;
  localparam int STROBE_W = 6;
  localparam int HOLD_W   = 4;
  localparam int CNT_W    = (STROBE_W > SETUP_W) ?
                            ((STROBE_W > HOLD_W) ? STROBE_W : HOLD_W) :
                            ((SETUP_W > HOLD_W) ? SETUP_W : HOLD_W);
  localparam int DATA_W   = 32;
  localparam int BYTES    = DATA_W / 8;
  localparam int BEAT_W   = $clog2(BYTES);

  typedef enum logic [1:0] {W8 = 2'd0, W16 = 2'd1, W32 = 2'd2, W_RSV = 2'd3} width_e;

  typedef struct packed {
    logic                to_en;
    logic                rdy_en;
    width_e              width;
    logic [HOLD_W-1:0]   hold;
    logic [STROBE_W-1:0] strobe;
    logic [SETUP_W-1:0]  setup;
  } cs_cfg_t;

  localparam int CFG_W = $bits(cs_cfg_t);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  function automatic width_e boot_width(logic [2:0] strap);
    case (strap)
      3'b001:  return W16;
      3'b010:  return W32;
      default: return W8;
    endcase
  endfunction

  function automatic cs_cfg_t slow_cfg(width_e w);
    cs_cfg_t c;
    c.to_en  = 1'b0;
    c.rdy_en = 1'b0;
    c.width  = w;
    c.hold   = '1;
    c.strobe = '1;
    c.setup  = '1;
    return c;
  endfunction
endpackage

// File: rtl/asmc_cfg_regs.sv
module asmc_cfg_regs
  import asmc_pkg::*;
#(
  parameter  int N_CS  = 4,
  localparam int SEL_W = $clog2(N_CS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2:0]           boot_mode_i,
  input  logic                 we_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [CFG_W-1:0]     wdata_i,
  output cs_cfg_t [N_CS-1:0]   cfg_o
);
  for (genvar g = 0; g < N_CS; g++) begin : g_cs
    cs_cfg_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        q <= slow_cfg((g == 0) ? boot_width(boot_mode_i) : W32);  // strap captured while in reset
      else if (we_i && sel_i == SEL_W'(g))
        q <= cs_cfg_t'(wdata_i);
    end
    assign cfg_o[g] = q;
  end
endmodule

// File: rtl/asmc_seq.sv
module asmc_seq
  import asmc_pkg::*;
#(
  parameter  int TIMEOUT_CYC = 16,
  localparam int TO_W        = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  cs_cfg_t           cfg_i,
  input  logic              rdy_ni,
  output phase_e            phase_o,
  output logic [BEAT_W-1:0] beat_o,
  output width_e            width_o,
  output logic              sample_o,
  output logic              done_o,
  output logic              err_o
);
  phase_e            phase_q;
  cs_cfg_t           cfg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TO_W-1:0]   wait_q;
  logic [BEAT_W-1:0] beat_q, last_beat;
  logic              err_q, cnt_zero, stall;

  always_comb begin
    case (cfg_q.width)
      W32:     last_beat = BEAT_W'(0);
      W16:     last_beat = BEAT_W'(1);
      default: last_beat = BEAT_W'(BYTES - 1);
    endcase
  end

  assign cnt_zero = (cnt_q == '0);
  assign stall    = cfg_q.rdy_en && rdy_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cfg_q   <= slow_cfg(W32);
      cnt_q   <= '0;
      wait_q  <= '0;
      beat_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SETUP;
          cfg_q   <= cfg_i;
          cnt_q   <= CNT_W'(cfg_i.setup);
          beat_q  <= '0;
          err_q   <= 1'b0;
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            phase_q <= PH_STROBE;
            cnt_q   <= CNT_W'(cfg_q.strobe);
            wait_q  <= '0;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_STROBE: begin
          if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
          else if (stall) begin
            if (cfg_q.to_en && wait_q == TO_W'(TIMEOUT_CYC - 1)) begin
              err_q   <= 1'b1;
              phase_q <= PH_HOLD;
              cnt_q   <= CNT_W'(cfg_q.hold);
            end else wait_q <= wait_q + 1'b1;
          end else begin
            phase_q <= PH_HOLD;
            cnt_q   <= CNT_W'(cfg_q.hold);
          end
        end
        PH_HOLD: begin
          if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
          else if (beat_q == last_beat || err_q) phase_q <= PH_IDLE;
          else begin
            beat_q  <= beat_q + 1'b1;
            phase_q <= PH_SETUP;
            cnt_q   <= CNT_W'(cfg_q.setup);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o  = phase_q;
  assign beat_o   = beat_q;
  assign width_o  = cfg_q.width;
  assign err_o    = err_q;
  assign sample_o = (phase_q == PH_STROBE) && cnt_zero && !stall;
  assign done_o   = (phase_q == PH_HOLD) && cnt_zero && (beat_q == last_beat || err_q);
endmodule

// File: rtl/asmc_lane.sv
module asmc_lane
  import asmc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sample_i,
  input  width_e            width_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [ADDR_W-3:0] word_i,
  input  logic [BYTES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ext_d_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTES-1:0]  be_no,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] step;

  always_comb begin
    case (width_i)
      W32: begin
        step    = ADDR_W'(beat_i) << 2;
        be_no   = ~be_i;
        wdata_o = wdata_i;
      end
      W16: begin
        step    = ADDR_W'(beat_i) << 1;
        be_no   = {2'b11, ~(beat_i[0] ? be_i[3:2] : be_i[1:0])};
        wdata_o = {16'hFFFF, beat_i[0] ? wdata_i[31:16] : wdata_i[15:0]};
      end
      default: begin
        step    = ADDR_W'(beat_i);
        be_no   = {3'b111, ~be_i[beat_i]};
        wdata_o = {24'hFFFFFF, wdata_i[{beat_i, 3'b000} +: 8]};
      end
    endcase
  end

  assign addr_o = {word_i, 2'b00} + step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (start_i) rdata_o <= '0;
    else if (sample_i) begin
      case (width_i)
        W32: rdata_o <= ext_d_i;
        W16: if (beat_i[0]) rdata_o[31:16] <= ext_d_i[15:0];
             else           rdata_o[15:0]  <= ext_d_i[15:0];
        default: rdata_o[{beat_i, 3'b000} +: 8] <= ext_d_i[7:0];
      endcase
    end
  end
endmodule

// File: rtl/asmc_top.sv
module asmc_top
  import asmc_pkg::*;
#(
  parameter  int N_CS        = 4,
  parameter  int ADDR_W      = 24,
  parameter  int TIMEOUT_CYC = 16,
  localparam int SEL_W       = $clog2(N_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        boot_mode_i,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [SEL_W-1:0]  req_cs_i,
  input  logic [ADDR_W-3:0] req_word_i,
  input  logic [BYTES-1:0]  req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [N_CS-1:0]   mem_cs_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTES-1:0]  mem_be_no,
  output logic              mem_rd_no,
  output logic              mem_wr_no,
  input  logic              mem_rdy_ni,
  input  logic [DATA_W-1:0] mem_d_i,
  output logic [DATA_W-1:0] mem_d_o,
  output logic              mem_d_oe_o
);
  cs_cfg_t [N_CS-1:0] cfg_all;
  phase_e             phase;
  width_e             width;
  logic [BEAT_W-1:0]  beat;
  logic               start, sample, done, err, active;
  logic               wr_q;
  logic [SEL_W-1:0]   cs_q;
  logic [ADDR_W-3:0]  word_q;
  logic [BYTES-1:0]   be_q;
  logic [DATA_W-1:0]  wdata_q, lane_wdata, lane_rdata;
  logic [ADDR_W-1:0]  lane_addr;
  logic [BYTES-1:0]   lane_be_n;

  asmc_cfg_regs #(.N_CS(N_CS)) u_cfg (
    .clk_i, .rst_ni, .boot_mode_i,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i), .cfg_o(cfg_all)
  );

  assign start = req_valid_i && (phase == PH_IDLE);

  asmc_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .cfg_i(cfg_all[req_cs_i]), .rdy_ni(mem_rdy_ni),
    .phase_o(phase), .beat_o(beat), .width_o(width),
    .sample_o(sample), .done_o(done), .err_o(err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      cs_q    <= '0;
      word_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (start) begin
      wr_q    <= req_write_i;
      cs_q    <= req_cs_i;
      word_q  <= req_word_i;
      be_q    <= req_be_i;
      wdata_q <= req_wdata_i;
    end
  end

  asmc_lane #(.ADDR_W(ADDR_W)) u_lane (
    .clk_i, .rst_ni, .start_i(start), .sample_i(sample && !wr_q),
    .width_i(width), .beat_i(beat), .word_i(word_q), .be_i(be_q),
    .wdata_i(wdata_q), .ext_d_i(mem_d_i),
    .addr_o(lane_addr), .be_no(lane_be_n), .wdata_o(lane_wdata), .rdata_o(lane_rdata)
  );

  assign active = (phase != PH_IDLE);

  for (genvar g = 0; g < N_CS; g++) begin : g_csn
    assign mem_cs_no[g] = !(active && cs_q == SEL_W'(g));
  end

  assign mem_addr_o  = active ? lane_addr : '0;
  assign mem_be_no   = active ? lane_be_n : '1;
  assign mem_rd_no   = !(phase == PH_STROBE && !wr_q);
  assign mem_wr_no   = !(phase == PH_STROBE && wr_q);
  // bus kept high except while a read owns it
  assign mem_d_oe_o  = !(active && !wr_q);
  assign mem_d_o     = (active && wr_q && (phase == PH_SETUP || phase == PH_STROBE)) ?
                       lane_wdata : '1;
  assign req_ready_o = !active;
  assign rsp_rdata_o = lane_rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= done;
      if (done) rsp_err_o <= err;
    end
  end
endmodule

// File: rtl/asmc_checker.sv
module asmc_checker #(
  parameter int N_CS = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_ready_o,
  input logic            rsp_valid_o,
  input logic [N_CS-1:0] mem_cs_no,
  input logic            mem_rd_no,
  input logic            mem_wr_no,
  input logic [31:0]     mem_d_o,
  input logic            mem_d_oe_o
);
  assert_one_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no));

  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_rd_no && !mem_wr_no));

  assert_setup_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mem_rd_no) || $fell(mem_wr_no)) |-> ($past(mem_cs_no) != '1));

  assert_read_released_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rd_no |-> !mem_d_oe_o);

  assert_wr_hold_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_wr_no) |-> (mem_d_oe_o && mem_d_o == '1));

  assert_rsp_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cs_no != '1) |-> !req_ready_o);
endmodule

bind asmc_top asmc_checker #(.N_CS(N_CS)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
  .mem_cs_no(mem_cs_no), .mem_rd_no(mem_rd_no), .mem_wr_no(mem_wr_no),
  .mem_d_o(mem_d_o), .mem_d_oe_o(mem_d_oe_o)
);

// File: tb/asmc_top_tb_top.sv
`timescale 1ns/1ps
module asmc_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  boot_mode_i = 3'b001;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [17:0] cfg_wdata_i = '0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [1:0]  req_cs_i = '0;
  logic [21:0] req_word_i = '0;
  logic [3:0]  req_be_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o, rsp_err_o;
  logic [31:0] rsp_rdata_o;
  logic [3:0]  mem_cs_no, mem_be_no;
  logic [23:0] mem_addr_o;
  logic        mem_rd_no, mem_wr_no, mem_d_oe_o;
  logic        mem_rdy_ni = 1'b0;
  logic [31:0] mem_d_i, mem_d_o;

  always #4 clk_i = ~clk_i;

  asmc_top dut_i (.*);

  int n_chk = 0, n_bad = 0, viol = 0;
  int pre_c, stb_c, gap_c, nstb;
  logic [23:0] addr_log [8];
  logic prev_stb = 1'b0, cur_write = 1'b0, cur_wide = 1'b0, finished = 1'b0;
  logic [7:0] ref_mem [4][256];
  logic [7:0] mdl     [4][256];

  typedef struct { logic chk_data; logic [31:0] data; logic err; string req; } exp_t;
  exp_t sb_q[$];

  function automatic int cs_idx(logic [3:0] csn);
    for (int i = 0; i < 4; i++) if (!csn[i]) return i;
    return 0;
  endfunction

  function automatic logic [17:0] mk_cfg(bit to, bit rdy, logic [1:0] w, int h, int st, int s);
    return {to, rdy, w, 4'(h), 6'(st), 4'(s)};
  endfunction

  // external device model
  always_comb begin
    int c;
    logic [7:0] a;
    c = cs_idx(mem_cs_no);
    a = mem_addr_o[7:0];
    mem_d_i = {mdl[c][8'(a + 8'd3)], mdl[c][8'(a + 8'd2)], mdl[c][8'(a + 8'd1)], mdl[c][a]};
  end

  always @(posedge clk_i) begin
    if (mem_cs_no != 4'hF && !mem_wr_no)
      for (int i = 0; i < 4; i++)
        if (!mem_be_no[i]) mdl[cs_idx(mem_cs_no)][8'(mem_addr_o[7:0] + 8'(i))] <= mem_d_o[8*i +: 8];
  end

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // pin monitor: phase lengths, beat addresses, bus drive
  always @(negedge clk_i) begin
    logic stb;
    stb = !mem_rd_no || !mem_wr_no;
    if (mem_cs_no != 4'hF) begin
      if (stb) begin
        stb_c++;
        if (!prev_stb) begin
          if (nstb < 8) addr_log[nstb] = mem_addr_o;
          nstb++;
        end
        gap_c = 0;
      end else if (nstb == 0) pre_c++;
      else gap_c++;
      if (!cur_write && mem_d_oe_o) viol++;
      if (cur_write && cur_wide && nstb > 0 && !stb && !(mem_d_oe_o && mem_d_o == '1)) viol++;
    end else if (rst_ni && !(mem_d_oe_o && mem_d_o == '1)) viol++;
    prev_stb = stb;
  end

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      if (sb_q.size() == 0) check("R11 unexpected response", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.req, " err"}, 32'(rsp_err_o), 32'(e.err));
        if (e.chk_data) check({e.req, " data"}, rsp_rdata_o, e.data);
      end
    end
  end

  task automatic access(input bit wr, input int cs, input int word, input logic [3:0] be,
                        input logic [31:0] wd, input bit exp_err, input string r);
    exp_t e;
    int base;
    base = word * 4;
    if (wr) for (int i = 0; i < 4; i++) if (be[i]) ref_mem[cs][base + i] = wd[8*i +: 8];
    e.chk_data = !wr && !exp_err;
    e.data = {ref_mem[cs][base + 3], ref_mem[cs][base + 2], ref_mem[cs][base + 1], ref_mem[cs][base]};
    e.err = exp_err;
    e.req = r;
    sb_q.push_back(e);
    pre_c = 0; stb_c = 0; gap_c = 0; nstb = 0;
    cur_write = wr;
    cur_wide = (cs == 1);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_cs_i = 2'(cs);
    req_word_i = 22'(word); req_be_i = be; req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (sb_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic write_cfg(input int cs, input logic [17:0] w);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = 2'(cs); cfg_wdata_i = w;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic reset_dut(input logic [2:0] strap);
    @(negedge clk_i);
    rst_ni = 1'b0; boot_mode_i = strap;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 256; a++) begin
        ref_mem[c][a] = 8'((a * 7 + c * 13 + 5) & 8'hFF);
        mdl[c][a] = ref_mem[c][a];
      end
    repeat (3) @(negedge clk_i);
    // R1: state in reset
    check("R1 cs in reset", 32'(mem_cs_no), 32'hF);
    check("R1 strobes in reset", 32'({mem_rd_no, mem_wr_no}), 32'h3);
    check("R1 drive high in reset", {31'd0, mem_d_oe_o} & 32'(mem_d_o == '1), 32'h1);
    check("R1 ready in reset", 32'({req_ready_o, rsp_valid_o}), 32'h2);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after reset", 32'({mem_cs_no, mem_be_no}), 32'hFF);

    // R9: boot strap 001 -> 16-bit, slowest timing
    access(0, 0, 4, 4'hF, 0, 0, "R9 R6 boot read 16-bit");
    check("R9 boot setup cycles", 32'(pre_c), 32'd16);
    check("R9 R4 boot beats 16-bit", 32'(nstb), 32'd2);
    check("R9 boot strobe cycles", 32'(stb_c), 32'd128);
    check("R9 boot hold cycles", 32'(gap_c), 32'd16);
    check("R4 second beat address", 32'(addr_log[1]), 32'h12);

    reset_dut(3'b010);
    access(0, 0, 4, 4'hF, 0, 0, "R9 boot read 32-bit");
    check("R9 boot beats 32-bit", 32'(nstb), 32'd1);
    reset_dut(3'b101);
    access(0, 0, 4, 4'hF, 0, 0, "R9 R6 boot read reserved code");
    check("R9 boot beats reserved code", 32'(nstb), 32'd4);
    check("R4 fourth beat address", 32'(addr_log[3]), 32'h13);

    write_cfg(1, mk_cfg(0, 0, 2'd2, 1, 2, 1));
    write_cfg(2, mk_cfg(0, 0, 2'd0, 0, 1, 0));
    write_cfg(3, mk_cfg(1, 1, 2'd1, 1, 1, 1));

    // R3: programmed timing on 32-bit region
    access(1, 1, 8, 4'hF, 32'hA1B2C3D4, 0, "R3 write cs1");
    check("R3 setup cycles", 32'(pre_c), 32'd2);
    check("R3 strobe cycles", 32'(stb_c), 32'd3);
    check("R3 hold cycles", 32'(gap_c), 32'd2);
    check("R2 R4 address cs1", 32'(addr_log[0]), 32'h20);
    access(0, 1, 8, 4'hF, 0, 0, "R3 R2 read cs1");
    check("R10 bus driven after read", {31'd0, mem_d_oe_o} & 32'(mem_d_o == '1), 32'h1);
    // R5: partial enables
    access(1, 1, 8, 4'b0101, 32'h11223344, 0, "R5 partial write cs1");
    access(0, 1, 8, 4'hF, 0, 0, "R5 read back partial");

    // R7: ready ignored when disabled
    mem_rdy_ni = 1'b1;
    access(0, 1, 8, 4'hF, 0, 0, "R7 ready ignored read");
    check("R7 strobe unextended", 32'(stb_c), 32'd3);
    mem_rdy_ni = 1'b0;

    // R4/R5/R6: 8-bit region
    access(1, 2, 16, 4'b1011, 32'hDEADBEEF, 0, "R5 8-bit write");
    check("R4 8-bit beats", 32'(nstb), 32'd4);
    check("R4 8-bit third address", 32'(addr_log[2]), 32'h42);
    access(0, 2, 16, 4'hF, 0, 0, "R6 8-bit read");

    // 16-bit region, ready delayed
    access(1, 3, 5, 4'b1110, 32'h55667788, 0, "R5 16-bit write");
    mem_rdy_ni = 1'b1;
    fork
      access(0, 3, 5, 4'hF, 0, 0, "R7 R6 16-bit read with wait");
      begin
        int k;
        k = 0;
        while (k < 5) begin
          @(negedge clk_i);
          if (!mem_rd_no) k++;
        end
        mem_rdy_ni = 1'b0;
      end
    join
    check("R7 strobe extended", 32'(stb_c), 32'd7);

    // R8: timeout
    mem_rdy_ni = 1'b1;
    access(0, 3, 6, 4'hF, 0, 1, "R8 timeout read");
    check("R8 beats after timeout", 32'(nstb), 32'd1);
    check("R8 strobe length to timeout", 32'(stb_c), 32'd17);
    mem_rdy_ni = 1'b0;
    access(0, 3, 5, 4'hF, 0, 0, "R8 recovery read");

    check("R10 bus drive monitor", 32'(viol), 32'd0);
    finish_run();
  end
endmodule